// File: doc/BRIEF.md
# Line Fill Buffer

The block collects one eight-word cache line returned by a system-bus slave and then answers reads from that line as if it were a one-line cache. A fill opens with `fill_start`, which latches the line address and whether the line is cacheable. Beats then arrive in whatever order the slave chooses. Each beat carries a 3-bit word index. On a 32-bit slave a beat holds one word. On a 64-bit slave a beat holds two adjacent words. A per-word valid mask records which words have arrived, and `line_complete` rises once all eight are present.

Read lookups present a line address and a word index. A lookup hits one cycle later, with the same latency as a cache hit, when the line matches the buffered one and that particular word has already arrived. This means the target word can be forwarded before the rest of the line lands. A non-cacheable line stays in the buffer and keeps serving reads, but it is never offered for copying into the data cache. Only a complete cacheable line raises `cache_fill_en`. The buffered line stays resident until the next `fill_start`.

Top module: `line_fill_buf`

## Requirements
- R1: After reset `line_complete`, `cache_fill_en` and `hit` are 0, `hit_data` is 0, and no line is open.
- R2: `fill_start` opens a new line on the next edge. It loads `fill_line` and `fill_noncache` and clears every word's valid bit. A beat presented in the same cycle as `fill_start` is dropped.
- R3: With `bus_wide` = 0, a beat stores `beat_data[31:0]` as word `beat_word_idx` and marks that word valid.
- R4: With `bus_wide` = 1 and an even `beat_word_idx` i, a beat stores `beat_data[31:0]` as word i and `beat_data[63:32]` as word i+1, and marks both valid. A wide beat with an odd index writes nothing.
- R5: Beats may arrive in any order. `line_complete` is 1 exactly when all eight words of the open line are valid.
- R6: A lookup hits in the following cycle (`hit` = 1, `hit_data` = the stored word) when a line is open, `lookup_line` equals the buffered line address, and word `lookup_word` was valid before the lookup edge. A beat in the same cycle as the lookup is not forwarded.
- R7: Any lookup that does not hit, and any cycle without a lookup, gives `hit` = 0 and `hit_data` = 0 in the following cycle.
- R8: `cache_fill_en` is 1 only while the line is complete and was opened with `fill_noncache` = 0. A non-cacheable line never raises it.
- R9: A buffered line keeps serving hits for any number of lookups until the next `fill_start` replaces it.
- R10: Beats that arrive while no line is open (after reset, before the first `fill_start`) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_start | input | 1 | Open a new line fill |
| fill_line | input | ADDR_W-5 | Line address of the new fill |
| fill_noncache | input | 1 | New line is non-cacheable |
| bus_wide | input | 1 | 1: 64-bit beats, 0: 32-bit beats |
| beat_valid | input | 1 | Beat present this cycle |
| beat_word_idx | input | 3 | Word position of the beat |
| beat_data | input | 64 | Beat payload; low half used in narrow mode |
| line_complete | output | 1 | All eight words valid |
| cache_fill_en | output | 1 | Complete cacheable line may be copied into the cache |
| lookup_valid | input | 1 | Read lookup present |
| lookup_line | input | ADDR_W-5 | Line address of the lookup |
| lookup_word | input | 3 | Word index of the lookup |
| hit | output | 1 | Lookup from the previous cycle hit |
| hit_data | output | 32 | Word returned on a hit, else 0 |

## Verification
The assertions assume that `bus_wide` stays constant during a fill. They also assume that a wide slave never sends an odd index except in the one deliberate illegal case, which must then leave the mask untouched. The stimulus picks the width once per fill and generates beat order as a shuffled set of legal indices. Odd wide indices are injected only in a directed case. Random lookups are biased toward the open line so that hits on partially filled lines are exercised, alongside misses on other lines.

// File: rtl/line_fill_buf.sv
module line_fill_buf #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fill_start,
  input  logic [ADDR_W-6:0]            fill_line,
  input  logic                         fill_noncache,
  input  logic                         bus_wide,
  input  logic                         beat_valid,
  input  logic [$clog2(WORDS)-1:0]     beat_word_idx,
  input  logic [2*WORD_W-1:0]          beat_data,
  output logic                         line_complete,
  output logic                         cache_fill_en,
  input  logic                         lookup_valid,
  input  logic [ADDR_W-6:0]            lookup_line,
  input  logic [$clog2(WORDS)-1:0]     lookup_word,
  output logic                         hit,
  output logic [WORD_W-1:0]            hit_data
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int LINE_W = ADDR_W - 5;

  logic [WORD_W-1:0] words [WORDS];
  logic [WORDS-1:0]  valid_mask;
  logic [LINE_W-1:0] cur_line;
  logic              line_open, cur_nc;

  logic              beat_ok, wr_lo, wr_hi, lk_hit;
  logic [IDX_W-1:0]  hi_idx;
  logic [WORDS-1:0]  lo_bit, hi_bit;

  assign beat_ok = beat_valid & line_open & ~fill_start;
  assign wr_lo   = beat_ok & (~bus_wide | ~beat_word_idx[0]);
  assign wr_hi   = beat_ok & bus_wide & ~beat_word_idx[0];
  assign hi_idx  = beat_word_idx | IDX_W'(1);
  assign lo_bit  = wr_lo ? (WORDS'(1) << beat_word_idx) : '0;
  assign hi_bit  = wr_hi ? (WORDS'(1) << hi_idx) : '0;
  assign lk_hit  = lookup_valid & line_open & (lookup_line == cur_line) & valid_mask[lookup_word];

  assign line_complete = &valid_mask;
  assign cache_fill_en = line_complete & ~cur_nc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_open  <= 1'b0;
      cur_nc     <= 1'b0;
      cur_line   <= '0;
      valid_mask <= '0;
    end else if (fill_start) begin
      line_open  <= 1'b1;
      cur_nc     <= fill_noncache;
      cur_line   <= fill_line;
      valid_mask <= '0;
    end else begin
      valid_mask <= valid_mask | lo_bit | hi_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_lo) words[beat_word_idx] <= beat_data[WORD_W-1:0];
    if (wr_hi) words[hi_idx]        <= beat_data[2*WORD_W-1:WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      hit_data <= '0;
    end else begin
      hit      <= lk_hit;
      hit_data <= lk_hit ? words[lookup_word] : '0;
    end
  end
endmodule

// File: rtl/line_fill_buf_chk.sv
module line_fill_buf_chk #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     fill_start,
  input logic                     bus_wide,
  input logic                     beat_valid,
  input logic [$clog2(WORDS)-1:0] beat_word_idx,
  input logic                     lookup_valid,
  input logic                     hit,
  input logic [WORD_W-1:0]        hit_data,
  input logic                     line_complete,
  input logic                     cache_fill_en,
  input logic [WORDS-1:0]         valid_mask
);
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |=> (valid_mask == '0) && !line_complete);

  p_odd_wide_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && bus_wide && beat_word_idx[0] && !fill_start) |=> $stable(valid_mask));

  p_mask_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_start |=> ((valid_mask & $past(valid_mask)) == $past(valid_mask)));

  p_hit_needs_lookup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> !hit);

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_data == '0));

  p_copy_needs_complete_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cache_fill_en |-> line_complete);
endmodule

bind line_fill_buf line_fill_buf_chk #(.WORD_W(WORD_W), .WORDS(WORDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .bus_wide(bus_wide),
  .beat_valid(beat_valid), .beat_word_idx(beat_word_idx), .lookup_valid(lookup_valid),
  .hit(hit), .hit_data(hit_data), .line_complete(line_complete),
  .cache_fill_en(cache_fill_en), .valid_mask(valid_mask)
);

// File: tb/line_fill_buf_tb_top.sv
module line_fill_buf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        fill_start = 0, fill_noncache = 0, bus_wide = 0, beat_valid = 0, lookup_valid = 0;
  logic [26:0] fill_line = '0, lookup_line = '0;
  logic [2:0]  beat_word_idx = '0, lookup_word = '0;
  logic [63:0] beat_data = '0;
  logic        line_complete, cache_fill_en, hit;
  logic [31:0] hit_data;

  line_fill_buf dut_i (
    .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .fill_line(fill_line),
    .fill_noncache(fill_noncache), .bus_wide(bus_wide), .beat_valid(beat_valid),
    .beat_word_idx(beat_word_idx), .beat_data(beat_data), .line_complete(line_complete),
    .cache_fill_en(cache_fill_en), .lookup_valid(lookup_valid), .lookup_line(lookup_line),
    .lookup_word(lookup_word), .hit(hit), .hit_data(hit_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mw [8];
  logic [7:0]  mm = '0;
  logic        mv = 0, mnc = 0;
  logic [26:0] ml = '0;

  function automatic logic exp_hit(logic lv, logic [26:0] ll, logic [2:0] lw);
    return lv && mv && (ll == ml) && mm[lw];
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic st, logic [26:0] fl, logic nc, logic wd,
                      logic bv, logic [2:0] bi, logic [63:0] bd,
                      logic lv, logic [26:0] ll, logic [2:0] lw);
    logic eh;
    logic [31:0] ed;
    fill_start = st; fill_line = fl; fill_noncache = nc; bus_wide = wd;
    beat_valid = bv; beat_word_idx = bi; beat_data = bd;
    lookup_valid = lv; lookup_line = ll; lookup_word = lw;
    eh = exp_hit(lv, ll, lw);
    ed = eh ? mw[lw] : 32'h0;
    if (st) begin
      mv = 1; ml = fl; mnc = nc; mm = '0;
    end else if (bv && mv) begin
      if (!wd) begin
        mw[bi] = bd[31:0]; mm[bi] = 1'b1;
      end else if (!bi[0]) begin
        mw[bi] = bd[31:0]; mw[bi+1] = bd[63:32]; mm[bi] = 1'b1; mm[bi+1] = 1'b1;
      end
    end
    @(posedge clk); #2;
    check(tag, "hit", {31'd0, hit}, {31'd0, eh});
    check(tag, "hit_data", hit_data, ed);
    check(tag, "line_complete", {31'd0, line_complete}, {31'd0, &mm});
    check(tag, "cache_fill_en", {31'd0, cache_fill_en}, {31'd0, (&mm) & ~mnc});
    @(negedge clk);
  endtask

  task automatic idle_lookup(string tag, logic [26:0] ll, logic [2:0] lw);
    step(tag, 0, 0, 0, bus_wide, 0, 0, 0, 1, ll, lw);
  endtask

  task automatic beat(string tag, logic wd, logic [2:0] bi, logic [63:0] bd);
    step(tag, 0, 0, 0, wd, 1, bi, bd, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ord [8];
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #2;
    check("R1", "line_complete", {31'd0, line_complete}, 0);
    check("R1", "cache_fill_en", {31'd0, cache_fill_en}, 0);
    check("R1", "hit", {31'd0, hit}, 0);
    check("R1", "hit_data", hit_data, 0);
    @(negedge clk);
    rst_n = 1;

    beat("R10", 0, 3'd0, 64'h1111);
    idle_lookup("R10", 27'd0, 3'd0);

    step("R2", 1, 27'h123, 0, 0, 1, 3'd0, 64'hdead, 0, 0, 0);
    idle_lookup("R2", 27'h123, 3'd0);

    beat("R3", 0, 3'd5, 64'hffff_ffff_aaaa_0005);
    idle_lookup("R6", 27'h123, 3'd5);
    idle_lookup("R7", 27'h124, 3'd5);
    idle_lookup("R7", 27'h123, 3'd4);
    step("R6", 0, 0, 0, 0, 1, 3'd4, 64'h44, 1, 27'h123, 3'd4);
    idle_lookup("R6", 27'h123, 3'd4);

    step("R4", 1, 27'h200, 0, 1, 0, 0, 0, 0, 0, 0);
    beat("R4", 1, 3'd3, 64'h0000_0033_0000_0032);
    idle_lookup("R4", 27'h200, 3'd3);
    beat("R4", 1, 3'd2, 64'hbbbb_0003_aaaa_0002);
    idle_lookup("R4", 27'h200, 3'd2);
    idle_lookup("R4", 27'h200, 3'd3);
    beat("R5", 1, 3'd6, 64'h7_0000_0006);
    beat("R5", 1, 3'd0, 64'h1_0000_0000);
    beat("R5", 1, 3'd4, 64'h5_0000_0004);
    idle_lookup("R8", 27'h200, 3'd7);

    step("R8", 1, 27'h300, 1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 7; i >= 0; i--) beat("R8", 0, 3'(i), {32'h0, 32'h300 + i});
    for (int i = 0; i < 8; i++) idle_lookup("R9", 27'h300, 3'(i));
    step("R9", 1, 27'h301, 0, 0, 0, 0, 0, 1, 27'h300, 3'd0);
    idle_lookup("R9", 27'h300, 3'd0);

    for (int f = 0; f < 60; f++) begin
      logic wd, nc;
      logic [26:0] ln;
      int n;
      wd = 1'($urandom);
      nc = 1'($urandom);
      ln = 27'($urandom % 4);
      n = wd ? 4 : 8;
      for (int i = 0; i < n; i++) ord[i] = wd ? 2 * i : i;
      for (int i = n - 1; i > 0; i--) begin
        int j = int'($urandom % (i + 1));
        int t = ord[i]; ord[i] = ord[j]; ord[j] = t;
      end
      step("R2", 1, ln, nc, wd, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < n; i++) begin
        logic [26:0] ll;
        ll = ($urandom % 4 == 0) ? 27'($urandom % 4) : ln;
        step(wd ? "R4" : "R3", 0, 0, 0, wd, 1, 3'(ord[i]), {$urandom, $urandom},
             1'($urandom), ll, 3'($urandom));
        idle_lookup("R6", ll, 3'($urandom));
      end
      repeat (3) idle_lookup("R9", ln, 3'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule